// File: doc/BRIEF.md
# Configuration Space Access Translator

This block sits on the host side of a downstream configuration bus and turns processor I/O port cycles into configuration read and write requests. It decodes two legacy access methods that share the same port range. The run-time input `mode_two` chooses which one is live. Method one keeps a 32-bit address register at port 0xCF8 and opens a four-byte data window at 0xCFC. Method two uses a byte-wide key/function register at 0xCF8, a bus-forward byte at 0xCFA and a per-device I/O window at 0xC000–0xCFFF.

The I/O side is dword-oriented. `io_addr[15:2]` selects the dword and `io_addr[1:0]` is ignored. `io_be[3:0]` marks the active byte lanes, with lane n meaning byte address offset n, so a byte at 0xCFE shows up as dword 0xCFC with `io_be = 4'b0100`. Each access is one clock long. When the block handles an access it raises `io_claim` and returns read data on `io_rdata` in the same cycle. When it does not claim the access, the cycle passes through to ordinary I/O. A configuration request (`cfg_req`) is also combinational in that cycle. The target answers with `cfg_hit` and `cfg_rdata` during that same cycle.

Top module: `cfg_port_xlat`

## Requirements
- R1: After reset the method-one address register, the method-two key/function byte and the forward byte are all zero, so reads of 0xCF8 return 0 in either method.
- R2: In method one, a write to 0xCF8 with `io_be = 4'hF` stores the value with bits 30:24 and 1:0 forced to zero, and a full read of 0xCF8 returns the stored value.
- R3: In method one, an access to 0xCF8 whose byte enables are not all set is not claimed (`io_claim = 0`, `io_rdata = 0`) and leaves the address register unchanged.
- R4: In method one, with register bit 31 set, an access to 0xCFC raises `cfg_req` and is claimed. The request fields are bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register = bits 7:2. `cfg_be` equals `io_be`. `cfg_type` is 1 exactly when the bus is nonzero.
- R5: In method one, while register bit 31 is clear, an access to 0xCFC raises neither `cfg_req` nor `io_claim`.
- R6: A claimed read that raises `cfg_req` returns `cfg_rdata` when `cfg_hit` is 1 and 0xFFFFFFFF when `cfg_hit` is 0.
- R7: In method two, a write to dword 0xCF8 with lane 0 enabled stores byte 0 of the data as the key/function byte. With lane 2 enabled it stores byte 2 as the forward byte. A read returns {8'h00, forward, 8'h00, key/function}, so writing 0x0E reads back as 0x0E.
- R8: In method two, with a nonzero key (upper nibble of the key/function byte), an access to address 0xCxxx raises `cfg_req`. The request fields are device = `io_addr[11:8]`, register = `io_addr[7:2]`, function = key/function bits 3:1 and bus = forward byte. `cfg_type` is 1 exactly when the bus is nonzero.
- R9: In method two, while the key is zero, accesses to 0xCxxx are neither claimed nor turned into requests.
- R10: Only the selected method decodes. With `mode_two = 0` the 0xCxxx window is not claimed. With `mode_two = 1` the 0xCFC data window is not claimed, even when method-one bit 31 is set.
- R11: A configuration write drives `cfg_we = 1` with `cfg_wdata = io_wdata`. Claimed writes and all unclaimed accesses return `io_rdata = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_two | input | 1 | 0 selects method one, 1 selects method two |
| io_addr | input | 16 | I/O port address (bits 1:0 ignored) |
| io_be | input | 4 | Byte-lane enables within the dword |
| io_rd | input | 1 | I/O read strobe (one cycle) |
| io_wr | input | 1 | I/O write strobe (one cycle) |
| io_wdata | input | 32 | I/O write data, lane-aligned |
| io_rdata | output | 32 | I/O read data |
| io_claim | output | 1 | Access handled by this block |
| cfg_req | output | 1 | Configuration request valid |
| cfg_we | output | 1 | Request is a write |
| cfg_type | output | 1 | 0 for local bus, 1 for bus behind a bridge |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 6 | Dword register index |
| cfg_be | output | 4 | Request byte enables |
| cfg_wdata | output | 32 | Request write data |
| cfg_rdata | input | 32 | Read data from the target |
| cfg_hit | input | 1 | A function responded to the request |

## Verification
The hardest situations to reach are those where a port's meaning depends on state left by earlier cycles. These include the method-one data window while bit 31 is clear, the method-two window while the key nibble is zero, and a mode switch that leaves method-one bit 31 set, so that 0xCFC must go unclaimed. The stimulus reaches them by writing the control registers in chosen orders: first enabling, then clearing, then switching mode with stale state in place. It also uses partial-lane writes to 0xCF8, which must leave the address register untouched in method one but update separate bytes in method two.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int REG_W = 6;
  localparam int DW    = 32;
  localparam int AW    = 16;
  localparam logic [AW-1:0] CTRL_PORT = 16'h0CF8;
  localparam logic [AW-1:0] DATA_PORT = 16'h0CFC;
  localparam logic [3:0]    WIN_NIB   = 4'hC;

  typedef struct packed {
    logic             ctype;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] rsel;
  } cfg_tgt_t;

  // Address register keeps enable, bus, device, function and dword register.
  function automatic logic [DW-1:0] m1_clean(input logic [DW-1:0] w);
    return {w[31], 7'd0, w[23:2], 2'b00};
  endfunction

  function automatic logic bus_type(input logic [BUS_W-1:0] b);
    return (b != '0);
  endfunction

  function automatic logic same_dword(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a[AW-1:2] == b[AW-1:2]);
  endfunction

  function automatic cfg_tgt_t m1_target(input logic [DW-1:0] a);
    cfg_tgt_t t;
    t.bus   = a[23:16];
    t.dev   = a[15:11];
    t.fn    = a[10:8];
    t.rsel  = a[7:2];
    t.ctype = bus_type(a[23:16]);
    return t;
  endfunction

  function automatic cfg_tgt_t m2_target(input logic [7:0] key_fn, input logic [7:0] fwd,
                                         input logic [AW-1:0] a);
    cfg_tgt_t t;
    t.bus   = fwd;
    t.dev   = {1'b0, a[11:8]};
    t.fn    = key_fn[3:1];
    t.rsel  = a[7:2];
    t.ctype = bus_type(fwd);
    return t;
  endfunction
endpackage

// File: rtl/cfgx_m1_decode.sv
module cfgx_m1_decode
  import cfgx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [AW-1:0] io_addr,
  input  logic [3:0]    io_be,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [DW-1:0] io_wdata,
  output logic          claim,
  output logic          req,
  output cfg_tgt_t      tgt,
  output logic [DW-1:0] reg_rd,
  output logic [DW-1:0] addr_q,
  output logic          en
);
  logic acc, hit_ctrl, hit_data;

  assign acc      = io_rd | io_wr;
  assign en       = addr_q[31];
  assign hit_ctrl = sel && same_dword(io_addr, CTRL_PORT) && (io_be == 4'hF);
  assign hit_data = sel && same_dword(io_addr, DATA_PORT) && en;
  assign claim    = acc && (hit_ctrl || hit_data);
  assign req      = acc && hit_data;
  assign tgt      = m1_target(addr_q);
  assign reg_rd   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                addr_q <= '0;
    else if (io_wr && hit_ctrl) addr_q <= m1_clean(io_wdata);
  end
endmodule

// File: rtl/cfgx_m2_decode.sv
module cfgx_m2_decode
  import cfgx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [AW-1:0] io_addr,
  input  logic [3:0]    io_be,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [DW-1:0] io_wdata,
  output logic          claim,
  output logic          req,
  output cfg_tgt_t      tgt,
  output logic [DW-1:0] reg_rd,
  output logic [7:0]    key_fn_q,
  output logic          key_open
);
  logic       acc, hit_ctrl, hit_win;
  logic [7:0] fwd_q;

  assign acc      = io_rd | io_wr;
  assign key_open = (key_fn_q[7:4] != 4'h0);
  assign hit_ctrl = sel && same_dword(io_addr, CTRL_PORT) && (io_be[0] || io_be[2]);
  assign hit_win  = sel && (io_addr[AW-1:12] == WIN_NIB) && key_open;
  assign claim    = acc && (hit_ctrl || hit_win);
  assign req      = acc && hit_win;
  assign tgt      = m2_target(key_fn_q, fwd_q, io_addr);
  assign reg_rd   = {8'h00, fwd_q, 8'h00, key_fn_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_fn_q <= '0;
      fwd_q    <= '0;
    end else if (io_wr && hit_ctrl) begin
      if (io_be[0]) key_fn_q <= io_wdata[7:0];
      if (io_be[2]) fwd_q    <= io_wdata[23:16];
    end
  end
endmodule

// File: rtl/cfg_port_xlat.sv
module cfg_port_xlat
  import cfgx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_two,
  input  logic [15:0]   io_addr,
  input  logic [3:0]    io_be,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [31:0]   io_wdata,
  output logic [31:0]   io_rdata,
  output logic          io_claim,
  output logic          cfg_req,
  output logic          cfg_we,
  output logic          cfg_type,
  output logic [7:0]    cfg_bus,
  output logic [4:0]    cfg_dev,
  output logic [2:0]    cfg_fn,
  output logic [5:0]    cfg_reg,
  output logic [3:0]    cfg_be,
  output logic [31:0]   cfg_wdata,
  input  logic [31:0]   cfg_rdata,
  input  logic          cfg_hit
);
  logic          m1_claim, m1_req, m1_en;
  logic          m2_claim, m2_req, m2_key_open;
  cfg_tgt_t      m1_tgt, m2_tgt, tgt;
  logic [DW-1:0] m1_rd, m2_rd, m1_addr_q;
  logic [7:0]    m2_cse_q;

  cfgx_m1_decode u_m1 (
    .clk(clk), .rst_n(rst_n), .sel(!mode_two), .io_addr(io_addr), .io_be(io_be),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .claim(m1_claim), .req(m1_req),
    .tgt(m1_tgt), .reg_rd(m1_rd), .addr_q(m1_addr_q), .en(m1_en)
  );

  cfgx_m2_decode u_m2 (
    .clk(clk), .rst_n(rst_n), .sel(mode_two), .io_addr(io_addr), .io_be(io_be),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .claim(m2_claim), .req(m2_req),
    .tgt(m2_tgt), .reg_rd(m2_rd), .key_fn_q(m2_cse_q), .key_open(m2_key_open)
  );

  assign tgt       = mode_two ? m2_tgt : m1_tgt;
  assign io_claim  = m1_claim | m2_claim;
  assign cfg_req   = m1_req | m2_req;
  assign cfg_we    = io_wr;
  assign cfg_type  = tgt.ctype;
  assign cfg_bus   = tgt.bus;
  assign cfg_dev   = tgt.dev;
  assign cfg_fn    = tgt.fn;
  assign cfg_reg   = tgt.rsel;
  assign cfg_be    = io_be;
  assign cfg_wdata = io_wdata;

  always_comb begin
    if (!io_rd || !io_claim) io_rdata = '0;
    else if (cfg_req)        io_rdata = cfg_hit ? cfg_rdata : '1;
    else                     io_rdata = mode_two ? m2_rd : m1_rd;
  end
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_two,
  input logic [15:0] io_addr,
  input logic [3:0]  io_be,
  input logic        io_rd,
  input logic        io_wr,
  input logic [31:0] io_rdata,
  input logic        io_claim,
  input logic        cfg_req,
  input logic        cfg_type,
  input logic [7:0]  cfg_bus,
  input logic        cfg_hit,
  input logic [31:0] m1_addr_q,
  input logic        m1_en,
  input logic [7:0]  m2_cse_q,
  input logic        m2_key_open
);
  assert_m1_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !mode_two) |-> m1_en);

  assert_m2_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && mode_two) |-> m2_key_open);

  assert_absent_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && cfg_req && !cfg_hit) |-> (io_rdata == 32'hFFFF_FFFF));

  assert_type_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_type == (cfg_bus != 8'h00)));

  assert_req_claimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> io_claim);

  assert_zero_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_addr_q[30:24] == 7'd0) && (m1_addr_q[1:0] == 2'd0));

  assert_narrow_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_two && io_wr && io_addr[15:2] == 14'h033E && io_be != 4'hF) |=> $stable(m1_addr_q));

  assert_key_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(m2_cse_q));

  assert_quiet_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_rd) |-> (io_rdata == 32'h0));
endmodule

bind cfg_port_xlat cfgx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_two(mode_two), .io_addr(io_addr), .io_be(io_be),
  .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata), .io_claim(io_claim),
  .cfg_req(cfg_req), .cfg_type(cfg_type), .cfg_bus(cfg_bus), .cfg_hit(cfg_hit),
  .m1_addr_q(m1_addr_q), .m1_en(m1_en), .m2_cse_q(m2_cse_q), .m2_key_open(m2_key_open)
);

// File: tb/cfg_port_xlat_tb.sv
module cfg_port_xlat_tb;
  logic        clk = 0, rst_n = 0, mode_two = 0;
  logic [15:0] io_addr = 0;
  logic [3:0]  io_be = 0;
  logic        io_rd = 0, io_wr = 0;
  logic [31:0] io_wdata = 0, io_rdata, cfg_wdata, cfg_rdata = 0;
  logic        io_claim, cfg_req, cfg_we, cfg_type, cfg_hit = 0;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;

  int checks = 0, failures = 0;
  bit done = 0;
  // reference model state
  int unsigned m_addr = 0;
  int unsigned m_cse = 0, m_fwd = 0;

  always #10 clk = ~clk;

  cfg_port_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .mode_two(mode_two), .io_addr(io_addr), .io_be(io_be),
    .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_claim(io_claim), .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_type(cfg_type),
    .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_reg(cfg_reg),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_hit(cfg_hit)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic io_cycle(input string tag, input logic [15:0] a, input logic [3:0] be,
                          input bit rd, input bit wr, input logic [31:0] wd,
                          input bit hit, input logic [31:0] trd);
    bit ctl, win, e_claim, e_req;
    int unsigned bus, dev, fn, rg, rb, e_rd;
    @(negedge clk);
    io_addr = a; io_be = be; io_rd = rd; io_wr = wr; io_wdata = wd;
    cfg_hit = hit; cfg_rdata = trd;
    if (!mode_two) begin
      ctl = (a[15:2] == 14'h033E) && (be == 4'hF);
      win = (a[15:2] == 14'h033F) && m_addr[31];
      bus = (m_addr >> 16) & 8'hFF; dev = (m_addr >> 11) & 5'h1F;
      fn  = (m_addr >> 8) & 3'h7;   rg  = (m_addr >> 2) & 6'h3F;
      rb  = m_addr;
    end else begin
      ctl = (a[15:2] == 14'h033E) && (be[0] || be[2]);
      win = (a[15:12] == 4'hC) && ((m_cse >> 4) != 0);
      bus = m_fwd; dev = a[11:8]; fn = (m_cse >> 1) & 7; rg = a[7:2];
      rb  = (m_fwd << 16) | m_cse;
    end
    e_claim = (rd || wr) && (ctl || win);
    e_req   = (rd || wr) && win;
    if (!rd || !e_claim) e_rd = 0;
    else if (e_req)      e_rd = hit ? trd : 32'hFFFF_FFFF;
    else                 e_rd = rb;
    #5;
    chk(tag, "claim", io_claim, e_claim);
    chk(tag, "req", cfg_req, e_req);
    chk(tag, "rdata", io_rdata, e_rd);
    if (e_req) begin
      chk(tag, "we", cfg_we, wr);
      chk(tag, "bus", cfg_bus, bus);
      chk(tag, "dev", cfg_dev, dev);
      chk(tag, "fn", cfg_fn, fn);
      chk(tag, "reg", cfg_reg, rg);
      chk(tag, "type", cfg_type, bus != 0);
      chk(tag, "be", cfg_be, be);
      if (wr) chk(tag, "wdata", cfg_wdata, wd);
    end
    @(posedge clk);
    if (wr && ctl) begin
      if (!mode_two) m_addr = wd & 32'h80FF_FFFC;
      else begin
        if (be[0]) m_cse = wd & 8'hFF;
        if (be[2]) m_fwd = (wd >> 16) & 8'hFF;
      end
    end
  endtask

  task automatic idle(input string tag);
    io_cycle(tag, 16'h0000, 4'h0, 0, 0, 32'h0, 0, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state in both methods
    io_cycle("R1", 16'h0CF8, 4'hF, 1, 0, 0, 0, 0);
    @(negedge clk) mode_two = 1;
    io_cycle("R1", 16'h0CF8, 4'h5, 1, 0, 0, 0, 0);
    @(negedge clk) mode_two = 0;
    // R2 sanitized address register
    io_cycle("R2", 16'h0CF8, 4'hF, 0, 1, 32'hFFFF_FFFF, 0, 0);
    io_cycle("R2", 16'h0CF8, 4'hF, 1, 0, 0, 0, 0);
    // R3 narrow accesses pass through
    io_cycle("R3", 16'h0CF8, 4'h1, 0, 1, 32'h0, 0, 0);
    io_cycle("R3", 16'h0CFA, 4'hC, 1, 0, 0, 0, 0);
    io_cycle("R3", 16'h0CF8, 4'hF, 1, 0, 0, 0, 0);
    // R5 enable clear
    io_cycle("R5", 16'h0CF8, 4'hF, 0, 1, 32'h0012_3404, 0, 0);
    io_cycle("R5", 16'h0CFC, 4'hF, 1, 0, 0, 1, 32'h1111_1111);
    io_cycle("R5", 16'h0CFC, 4'hF, 0, 1, 32'h2222_2222, 1, 0);
    // R4 bus 0, type 0, dword and byte lanes
    io_cycle("R4", 16'h0CF8, 4'hF, 0, 1, 32'h8000_0A14, 0, 0);
    io_cycle("R4", 16'h0CFC, 4'hF, 1, 0, 0, 1, 32'h1234_5678);
    io_cycle("R4", 16'h0CFE, 4'h4, 1, 0, 0, 1, 32'h00AB_0000);
    // R6 absent function
    io_cycle("R6", 16'h0CFC, 4'hF, 1, 0, 0, 0, 32'h5555_5555);
    // R4 R11 bus 3, type 1, top device and register, write
    io_cycle("R4", 16'h0CF8, 4'hF, 0, 1, 32'h8003_F8FC, 0, 0);
    io_cycle("R11", 16'h0CFC, 4'h3, 0, 1, 32'hCAFE_BABE, 1, 0);
    io_cycle("R6", 16'h0CFC, 4'h3, 1, 0, 0, 0, 0);
    // R10 method-two window ignored in method one
    io_cycle("R10", 16'h0C104, 4'hF, 1, 0, 0, 1, 32'h7);
    idle("R1");
    // method two
    @(negedge clk) mode_two = 1;
    io_cycle("R7", 16'h0CF8, 4'h1, 0, 1, 32'h0000_000E, 0, 0);
    io_cycle("R7", 16'h0CF8, 4'h1, 1, 0, 0, 0, 0);
    io_cycle("R7", 16'h0CF8, 4'h4, 0, 1, 32'h0005_0000, 0, 0);
    io_cycle("R7", 16'h0CF8, 4'h5, 1, 0, 0, 0, 0);
    // R9 key zero
    io_cycle("R9", 16'hC304, 4'hF, 1, 0, 0, 1, 32'h9);
    io_cycle("R9", 16'hC304, 4'hF, 0, 1, 32'h9, 1, 0);
    // R8 key open
    io_cycle("R8", 16'h0CF8, 4'h1, 0, 1, 32'h0000_008B, 0, 0);
    io_cycle("R8", 16'hC3F0, 4'hF, 1, 0, 0, 1, 32'hDEAD_BEEF);
    io_cycle("R11", 16'hCF08, 4'h2, 0, 1, 32'h0000_3300, 1, 0);
    io_cycle("R6", 16'hC000, 4'hF, 1, 0, 0, 0, 0);
    io_cycle("R8", 16'h0CF8, 4'h4, 0, 1, 32'h0, 0, 0);
    io_cycle("R8", 16'hC710, 4'hF, 1, 0, 0, 1, 32'h0BAD_F00D);
    // R10 method-one data window ignored in method two (bit 31 still set)
    io_cycle("R10", 16'h0CFC, 4'hF, 1, 0, 0, 1, 32'h1);
    // close key again
    io_cycle("R9", 16'h0CF8, 4'h1, 0, 1, 32'h0000_000E, 0, 0);
    io_cycle("R9", 16'hC3F0, 4'hF, 1, 0, 0, 1, 32'h1);
    idle("R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule